// File: doc/BRIEF.md
# CCD Electronic Shutter Controller

This block sets the exposure time of a CCD image sensor. It counts lines from a horizontal sync strobe and fields from a vertical sync strobe. From those counts it decides when to send a substrate discharge pulse, which empties the photodiodes, and when to send a charge-readout pulse. Integration starts once the discharge pulses stop. It ends at readout. Each pulse within a line is reduced to a one-clock strobe.

A 2-bit mode input picks one of four behaviours:

- **Fast shutter.** A 9-bit load value sets how many lines at the start of each field carry discharge pulses. The exposure is the rest of the field.
- **Anti-flicker.** A fixed line count tied to the mains lighting period, with one value for each video standard.
- **Shutter off.** No discharge pulses, so exposure lasts the whole field.
- **Slow shutter.** Integration stretches over N fields. Readout is allowed in only one field of every N, and a write-enable output marks that field for a downstream frame store.

A readout-inhibit input holds off all readout pulses. Outputs of this block feed the vertical driver of the sensor.

Top module: `ccd_shutter_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, dischargePulse, readoutPulse and writeEn are low, and the line and field counts are zero.
- R2: With modeSel = 2'b01 (fast shutter), each field carries exactly S = 0x1FF − loadVal discharge pulses. They fall on the first S line strobes after the field strobe, and each is high for one cycle, in the cycle after its line strobe.
- R3: With modeSel = 2'b00 (anti-flicker), the discharge count per field is 105 when palSel = 0 and 182 when palSel = 1, placed as in R2.
- R4: With modeSel = 2'b11 (shutter off), no discharge pulse is issued.
- R5: With modeSel = 2'b10 (slow shutter), no discharge pulse is issued. writeEn is high for one field in every N = 2 × (0x1FF − loadVal) fields. Counting fields from entry into the mode, the first high field is field N − 1. readoutPulse occurs only in fields where writeEn is high.
- R6: In slow-shutter mode, loadVal = 0x1FF acts as 0x1FE, giving N = 2.
- R7: In every mode other than slow shutter, each field carries one readoutPulse. It is high for one cycle, in the cycle after the line strobe that has exactly 3 earlier line strobes in the same field.
- R8: While readEnPin is low, no readoutPulse is issued. writeEn is not affected.
- R9: A field strobe that arrives together with a line strobe restarts the line count, and no pulse is issued for that line strobe.
- R10: writeEn changes only in the cycle after a field strobe and holds for the rest of the field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rstN | input | 1 | Active-low synchronous reset |
| hsyncStb | input | 1 | One-clock strobe at each line start |
| vsyncStb | input | 1 | One-clock strobe at each field start |
| modeSel | input | 2 | 00 anti-flicker, 01 fast, 10 slow, 11 off |
| loadVal | input | 9 | Exposure load value |
| palSel | input | 1 | 0: 525-line standard, 1: 625-line standard |
| readEnPin | input | 1 | 0 holds off readout pulses |
| dischargePulse | output | 1 | Substrate discharge strobe |
| readoutPulse | output | 1 | Charge readout strobe |
| writeEn | output | 1 | Frame-store write enable for the current field |

## Verification
Fast shutter is run with two load values, 5 and 15 discharge lines, each checked line by line. This separates a correct stop line from an off-by-one count and from pulses placed anywhere other than the start of the field. Anti-flicker is run over full fields of both standards, which shows that the standard select reaches the line limit. Shutter-off and slow-shutter fields must contain no discharge pulses. Slow-shutter runs with N = 4 and with the illegal load value, over several fields each, so the write-enable cadence, the readout gating and the substitution to N = 2 all show up. An inhibited readout, and a field strobe that coincides with a line strobe, exercise the gating and the counter priority.

// File: rtl/shutter_pkg.sv
package shutter_pkg;
  parameter int LOAD_W = 9;

  typedef enum logic [1:0] {
    MODE_FLICKERLESS = 2'b00,
    MODE_HIGH        = 2'b01,
    MODE_LOW         = 2'b10,
    MODE_OFF         = 2'b11
  } shutMode_e;

  // strobes and limits passed from control to datapath
  typedef struct packed {
    logic              lineStart;
    logic              fieldStart;
    logic              readGate;
    logic [LOAD_W-1:0] stopLines;
  } ctrlBus_t;
endpackage

// File: rtl/shutter_ctrl.sv
module shutter_ctrl
  import shutter_pkg::*;
#(
  parameter int FL_STOP_NTSC = 105,
  parameter int FL_STOP_PAL  = 182
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsyncStb,
  input  logic              vsyncStb,
  input  logic [1:0]        modeSel,
  input  logic [LOAD_W-1:0] loadVal,
  input  logic              palSel,
  input  logic              readEnPin,
  output ctrlBus_t          bus,
  output logic              writeEn
);
  localparam int FLD_W = LOAD_W + 1;
  localparam logic [LOAD_W-1:0] LOAD_MAX = '1;

  logic              lowMode;
  logic [LOAD_W-1:0] effLoad;
  logic [LOAD_W-1:0] span;
  logic [FLD_W-1:0]  lastField;
  logic [FLD_W-1:0]  fieldCnt;
  logic [FLD_W-1:0]  nextCnt;
  logic              wenQ;
  logic [LOAD_W-1:0] stopLines;

  assign lowMode   = (modeSel == MODE_LOW);
  // illegal all-ones load in slow mode is replaced by the next value down (R6)
  assign effLoad   = (lowMode && loadVal == LOAD_MAX) ? LOAD_MAX - 1'b1 : loadVal;
  assign span      = LOAD_MAX - effLoad;
  assign lastField = {span, 1'b0} - 1'b1;
  assign nextCnt   = (fieldCnt >= lastField) ? '0 : fieldCnt + 1'b1;

  always_comb begin
    case (modeSel)
      MODE_HIGH:        stopLines = span;
      MODE_FLICKERLESS: stopLines = palSel ? LOAD_W'(FL_STOP_PAL) : LOAD_W'(FL_STOP_NTSC);
      default:          stopLines = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fieldCnt <= '0;
      wenQ     <= 1'b0;
    end else if (vsyncStb) begin
      if (lowMode) begin
        fieldCnt <= nextCnt;
        wenQ     <= (nextCnt == lastField);
      end else begin
        fieldCnt <= '0;
        wenQ     <= 1'b0;
      end
    end
  end

  assign bus.lineStart  = hsyncStb;
  assign bus.fieldStart = vsyncStb;
  assign bus.readGate   = readEnPin && (!lowMode || wenQ);
  assign bus.stopLines  = stopLines;
  assign writeEn        = wenQ;

  // R10
  wen_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wenQ) |-> $past(vsyncStb));

  // R5
  wen_lowmode_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wenQ) |-> $past(modeSel == MODE_LOW));
endmodule

// File: rtl/shutter_dp.sv
module shutter_dp
  import shutter_pkg::*;
#(
  parameter int LINE_W    = 10,
  parameter int READ_LINE = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  ctrlBus_t bus,
  output logic     dischargePulse,
  output logic     readoutPulse
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [LINE_W-1:0] lineCnt;
  logic [LINE_W-1:0] stopExt;
  logic              dischQ;
  logic              readQ;

  assign stopExt = LINE_W'(bus.stopLines);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt <= '0;
      dischQ  <= 1'b0;
      readQ   <= 1'b0;
    end else begin
      dischQ <= 1'b0;
      readQ  <= 1'b0;
      if (bus.fieldStart) begin
        lineCnt <= '0;
      end else if (bus.lineStart) begin
        if (lineCnt != LINE_MAX) lineCnt <= lineCnt + 1'b1;
        dischQ <= (lineCnt < stopExt);
        readQ  <= (lineCnt == LINE_W'(READ_LINE)) && bus.readGate;
      end
    end
  end

  assign dischargePulse = dischQ;
  assign readoutPulse   = readQ;

  // R2 R9
  disch_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    dischQ |-> $past(bus.lineStart && !bus.fieldStart));

  // R7 R9
  read_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    readQ |-> $past(bus.lineStart && !bus.fieldStart));
endmodule

// File: rtl/ccd_shutter_top.sv
module ccd_shutter_top
  import shutter_pkg::*;
#(
  parameter int LINE_W       = 10,
  parameter int READ_LINE    = 3,
  parameter int FL_STOP_NTSC = 105,
  parameter int FL_STOP_PAL  = 182
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsyncStb,
  input  logic              vsyncStb,
  input  logic [1:0]        modeSel,
  input  logic [LOAD_W-1:0] loadVal,
  input  logic              palSel,
  input  logic              readEnPin,
  output logic              dischargePulse,
  output logic              readoutPulse,
  output logic              writeEn
);
  ctrlBus_t bus;

  shutter_ctrl #(
    .FL_STOP_NTSC(FL_STOP_NTSC),
    .FL_STOP_PAL (FL_STOP_PAL)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .hsyncStb (hsyncStb),
    .vsyncStb (vsyncStb),
    .modeSel  (modeSel),
    .loadVal  (loadVal),
    .palSel   (palSel),
    .readEnPin(readEnPin),
    .bus      (bus),
    .writeEn  (writeEn)
  );

  shutter_dp #(
    .LINE_W   (LINE_W),
    .READ_LINE(READ_LINE)
  ) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .bus           (bus),
    .dischargePulse(dischargePulse),
    .readoutPulse  (readoutPulse)
  );

  // R8
  read_inhibit_chk: assert property (@(posedge clk) disable iff (!rstN)
    readoutPulse |-> $past(readEnPin));

  // R4
  off_nodisch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(modeSel == MODE_OFF) |-> !dischargePulse);

  // R5
  low_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readoutPulse && $past(modeSel == MODE_LOW)) |-> writeEn);
endmodule

// File: tb/sim_ccd_shutter_top.sv
module sim_ccd_shutter_top;
  import shutter_pkg::*;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hsyncStb = 1'b0;
  logic       vsyncStb = 1'b0;
  logic [1:0] modeSel = MODE_OFF;
  logic [8:0] loadVal = 9'h1F0;
  logic       palSel = 1'b0;
  logic       readEnPin = 1'b1;
  logic       dischargePulse, readoutPulse, writeEn;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  ccd_shutter_top u0 (
    .clk(clk), .rstN(rstN), .hsyncStb(hsyncStb), .vsyncStb(vsyncStb),
    .modeSel(modeSel), .loadVal(loadVal), .palSel(palSel), .readEnPin(readEnPin),
    .dischargePulse(dischargePulse), .readoutPulse(readoutPulse), .writeEn(writeEn)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one strobe cycle; returns at the negedge where the registered result shows
  task automatic strobe(bit h, bit v);
    @(negedge clk);
    hsyncStb = h;
    vsyncStb = v;
    @(negedge clk);
    hsyncStb = 1'b0;
    vsyncStb = 1'b0;
  endtask

  task automatic runField(string tag, int lines, int expS, bit expRead, bit expWen, bit both);
    int dCnt = 0;
    int rCnt = 0;
    int bad = 0;
    strobe(both, 1'b1);
    check({tag, " writeEn at field start (R10)"}, writeEn, expWen);
    if (both) check({tag, " no pulse on joint strobe (R9)"}, dischargePulse + readoutPulse, 0);
    for (int k = 0; k < lines; k++) begin
      strobe(1'b1, 1'b0);
      if (dischargePulse) dCnt++;
      if (readoutPulse) rCnt++;
      if (dischargePulse != (k < expS)) bad++;
      if (readoutPulse != (expRead && k == 3)) bad++;
      @(negedge clk);
      if (dischargePulse || readoutPulse) bad++;
    end
    check({tag, " discharge count"}, dCnt, expS);
    check({tag, " readout count"}, rCnt, int'(expRead));
    check({tag, " pulse placement"}, bad, 0);
    check({tag, " writeEn held (R10)"}, writeEn, expWen);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1 reset discharge", dischargePulse, 0);
    check("R1 reset readout", readoutPulse, 0);
    check("R1 reset writeEn", writeEn, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 post-reset outputs", dischargePulse + readoutPulse + writeEn, 0);
  endtask

  task automatic testHigh();
    modeSel = MODE_HIGH;
    loadVal = 9'h1F0;
    runField("R2 R7 fast S=15", 20, 15, 1'b1, 1'b0, 1'b0);
    loadVal = 9'h1FA;
    runField("R2 R7 fast S=5", 12, 5, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testInhibit();
    modeSel = MODE_HIGH;
    loadVal = 9'h1FA;
    readEnPin = 1'b0;
    runField("R8 readout inhibited", 10, 5, 1'b0, 1'b0, 1'b0);
    readEnPin = 1'b1;
  endtask

  task automatic testFlicker();
    modeSel = MODE_FLICKERLESS;
    palSel = 1'b0;
    runField("R3 anti-flicker 525", 262, 105, 1'b1, 1'b0, 1'b0);
    palSel = 1'b1;
    runField("R3 anti-flicker 625", 312, 182, 1'b1, 1'b0, 1'b0);
    palSel = 1'b0;
  endtask

  task automatic testOff();
    modeSel = MODE_OFF;
    runField("R4 shutter off", 20, 0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testLow();
    bit pattern[7] = '{0, 0, 1, 0, 0, 0, 1};
    modeSel = MODE_OFF;
    runField("R5 prep off", 6, 0, 1'b1, 1'b0, 1'b0);
    modeSel = MODE_LOW;
    loadVal = 9'h1FD;
    for (int f = 0; f < 7; f++)
      runField($sformatf("R5 slow N=4 field %0d", f), 6, 0, pattern[f], pattern[f], 1'b0);
  endtask

  task automatic testIllegal();
    modeSel = MODE_OFF;
    runField("R6 prep off", 6, 0, 1'b1, 1'b0, 1'b0);
    modeSel = MODE_LOW;
    loadVal = 9'h1FF;
    runField("R6 slow 0x1FF field 0", 6, 0, 1'b1, 1'b1, 1'b0);
    runField("R6 slow 0x1FF field 1", 6, 0, 1'b0, 1'b0, 1'b0);
    runField("R6 slow 0x1FF field 2", 6, 0, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic testJoint();
    modeSel = MODE_HIGH;
    loadVal = 9'h1FA;
    runField("R9 joint strobe field", 10, 5, 1'b1, 1'b0, 1'b1);
  endtask

  initial begin
    testReset();
    testHigh();
    testInhibit();
    testFlicker();
    testOff();
    testLow();
    testIllegal();
    testJoint();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1-all actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule